// File: doc/BRIEF.md
# PCM Master Bit Clock, Frame Sync and Stereo Serializer

This block is the master side of a short-frame serial audio link. It takes one of two source clocks and divides it into a bit clock. It counts bit clocks into frames and marks the first bit of each frame with a one-bit-wide sync pulse. In each frame it shifts two 16-bit words out and samples two 16-bit words in. The source clocks reach the block as single-cycle tick strobes in the system clock domain, so the whole block runs on one clock.

Each direction has its own option that delays the first data bit by one bit clock after the sync pulse. Without the delay, the first data bit shares its slot with the sync pulse. Words leave most significant bit first. The transmit line changes when the bit clock falls, and receive data is sampled when it rises. When the transmit FIFO has no word ready at the start of a word slot, the block sends zeros and flags an underrun.

The clock runs only while its enable is set, and then only if a direction is enabled or the continuous-idle mode is selected. Divider values are taken at start-up and at frame boundaries only.

Top module: `pcm_master_serdes`

## Requirements
- R1: While running, `sclk_out` starts low and toggles after every `sclk_div`+1 selected ticks, so one bit period lasts 2*(`sclk_div`+1) selected ticks.
- R2: `src_sel`=1 selects `tick_periph` and `src_sel`=0 selects `tick_audio`. Ticks of the unselected source have no effect on `sclk_out`.
- R3: A frame has `sync_div`+1 bit periods. `sync_out` is high for exactly the first bit period of each frame, and it rises while `sclk_out` is low.
- R4: `sclk_div` and `sync_div` are captured when the clock starts and again at each frame wrap. A change made in the middle of a frame first takes effect in the next frame.
- R5: With `tx_en` set, transmit slot p = bit index − `tx_msb_late` (0..31) carries bit 15−(p mod 16) of word p/16. A new word is taken at p=0 and p=16, and `tx_take` pulses one cycle, aligned with the first bit on `sdo`. `sdo` changes only at bit-period starts and is 0 outside slots or when `tx_en` is clear.
- R6: With `rx_en` set, `sdi` is sampled on each rising `sclk_out` in slots p = bit index − `rx_msb_late` (0..31), MSB first. After each 16th bit, `rx_wr` pulses one cycle with the word on `rx_data`. Bits outside the slots are ignored.
- R7: If `tx_valid` is low at a word start, the block sends zeros for that word and pulses `tx_underrun` instead of `tx_take`.
- R8: The clock runs only when `sclk_en` is set and (`idle_cont` or `tx_en` or `rx_en`) is set. Otherwise `sclk_out`, `sync_out` and `sdo` are 0 on the next cycle and the frame restarts from bit 0.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | 1 selects peripheral ticks, 0 selects audio-bus ticks |
| tick_periph | input | 1 | Peripheral source clock tick strobe |
| tick_audio | input | 1 | Audio-bus source clock tick strobe |
| sclk_div | input | 9 | Bit clock half-period minus one, in ticks |
| sync_div | input | 9 | Frame length minus one, in bit periods |
| sclk_en | input | 1 | Bit clock enable |
| idle_cont | input | 1 | 1 keeps the clock running with both directions off |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_msb_late | input | 1 | Transmit MSB one bit after sync |
| rx_msb_late | input | 1 | Receive MSB one bit after sync |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | 16 | Transmit FIFO head word |
| tx_take | output | 1 | Pop strobe toward the transmit FIFO |
| tx_underrun | output | 1 | Word slot found the transmit FIFO empty |
| rx_wr | output | 1 | Push strobe toward the receive FIFO |
| rx_data | output | 16 | Received word |
| sclk_out | output | 1 | Bit clock |
| sync_out | output | 1 | Frame sync pulse |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest case to reach is a divider change in the middle of a frame. The old values must hold until the wrap and the new ones must apply from the next sync. The bench waits for a sync edge, rewrites both dividers a few cycles later, and measures the bit count of the two following frames. Underrun at a word start is reached by letting the bench FIFO drain while frames keep running. The truncated-word case is reached with a 32-bit frame and a late receive MSB.

// File: rtl/pcm_master_serdes.sv
module pcm_master_serdes #(
  parameter int WORD_W   = 16,
  parameter int DIV_W    = 9,
  parameter int CHANNELS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_sel,
  input  logic              tick_periph,
  input  logic              tick_audio,
  input  logic [DIV_W-1:0]  sclk_div,
  input  logic [DIV_W-1:0]  sync_div,
  input  logic              sclk_en,
  input  logic              idle_cont,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_msb_late,
  input  logic              rx_msb_late,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_take,
  output logic              tx_underrun,
  output logic              rx_wr,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk_out,
  output logic              sync_out,
  output logic              sdo,
  input  logic              sdi
);
  localparam int SLOT_BITS = WORD_W * CHANNELS;
  localparam int POS_W     = DIV_W + 1;
  localparam int BIT_W     = $clog2(WORD_W);

  logic              run, tick, started, sclk_q, sync_q, sdo_q;
  logic [DIV_W-1:0]  div_cnt, cur_sd, cur_fd, bit_cnt, nb;
  logic              half_end, fall, rise, wrap, bit_go;
  logic [POS_W-1:0]  tx_off, rx_off, tx_pos, rx_pos;
  logic              tx_slot, tx_first, rx_slot, rx_last;
  logic [WORD_W-1:0] tx_sh, tx_word;
  logic [WORD_W-2:0] rx_sh;

  assign run      = sclk_en & (idle_cont | tx_en | rx_en);
  assign tick     = src_sel ? tick_periph : tick_audio;
  assign half_end = started & tick & (div_cnt == cur_sd);
  assign fall     = half_end & sclk_q;
  assign rise     = half_end & ~sclk_q;
  assign wrap     = (bit_cnt == cur_fd);
  assign nb       = (!started || wrap) ? '0 : bit_cnt + 1'b1;
  assign bit_go   = run & (~started | fall);

  assign tx_off   = POS_W'(tx_msb_late);
  assign tx_pos   = {1'b0, nb} - tx_off;
  assign tx_slot  = tx_en & ({1'b0, nb} >= tx_off) & (tx_pos < POS_W'(SLOT_BITS));
  assign tx_first = (tx_pos[BIT_W-1:0] == '0);
  assign tx_word  = tx_valid ? tx_data : '0;

  assign rx_off   = POS_W'(rx_msb_late);
  assign rx_pos   = {1'b0, bit_cnt} - rx_off;
  assign rx_slot  = rx_en & ({1'b0, bit_cnt} >= rx_off) & (rx_pos < POS_W'(SLOT_BITS));
  assign rx_last  = (rx_pos[BIT_W-1:0] == BIT_W'(WORD_W - 1));

  assign sclk_out = sclk_q;
  assign sync_out = sync_q;
  assign sdo      = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started     <= 1'b0;
      sclk_q      <= 1'b0;
      sync_q      <= 1'b0;
      sdo_q       <= 1'b0;
      div_cnt     <= '0;
      bit_cnt     <= '0;
      cur_sd      <= '0;
      cur_fd      <= '0;
      tx_sh       <= '0;
      rx_sh       <= '0;
      rx_data     <= '0;
      tx_take     <= 1'b0;
      tx_underrun <= 1'b0;
      rx_wr       <= 1'b0;
    end else begin
      tx_take     <= 1'b0;
      tx_underrun <= 1'b0;
      rx_wr       <= 1'b0;
      if (!run) begin
        started <= 1'b0;
        sclk_q  <= 1'b0;
        sync_q  <= 1'b0;
        sdo_q   <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
      end else begin
        if (!started) begin
          started <= 1'b1;
          cur_sd  <= sclk_div;
          cur_fd  <= sync_div;
          div_cnt <= '0;
        end else if (tick) begin
          if (div_cnt == cur_sd) begin
            div_cnt <= '0;
            sclk_q  <= ~sclk_q;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        if (fall) begin
          bit_cnt <= nb;
          if (wrap) begin
            cur_sd <= sclk_div;
            cur_fd <= sync_div;
          end
        end
        if (bit_go) begin
          sync_q <= (nb == '0);
          if (tx_slot) begin
            if (tx_first) begin
              sdo_q       <= tx_word[WORD_W-1];
              tx_sh       <= {tx_word[WORD_W-2:0], 1'b0};
              tx_take     <= tx_valid;
              tx_underrun <= ~tx_valid;
            end else begin
              sdo_q <= tx_sh[WORD_W-1];
              tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end
          end else begin
            sdo_q <= 1'b0;
          end
        end
        if (rise && rx_slot) begin
          rx_sh <= {rx_sh[WORD_W-3:0], sdi};
          if (rx_last) begin
            rx_wr   <= 1'b1;
            rx_data <= {rx_sh, sdi};
          end
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (!sclk_out && !sync_out && !sdo)); // R8
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (started && run && !tick) |=> $stable(sclk_out)); // R2
  AST_FRAME_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (started && bit_cnt != '0) |-> ($stable(cur_sd) && $stable(cur_fd))); // R4
  AST_SYNC_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n) $rose(sync_out) |-> !sclk_out); // R3
  AST_TAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(tx_take && tx_underrun)); // R7
  AST_RX_SPACED: assert property (@(posedge clk) disable iff (!rst_n) rx_wr |=> !rx_wr); // R6
endmodule

// File: tb/pcm_master_serdes_tb_top.sv
module pcm_master_serdes_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic src_sel = 1'b1, tick_periph = 1'b0, tick_audio = 1'b0;
  logic [8:0] sclk_div = 9'd1, sync_div = 9'd127;
  logic sclk_en = 1'b0, idle_cont = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic tx_msb_late = 1'b0, rx_msb_late = 1'b0, tx_valid = 1'b0, sdi = 1'b0;
  logic [15:0] tx_data = '0, rx_data;
  logic tx_take, tx_underrun, rx_wr, sclk_out, sync_out, sdo;

  pcm_master_serdes dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .tick_periph(tick_periph),
    .tick_audio(tick_audio), .sclk_div(sclk_div), .sync_div(sync_div),
    .sclk_en(sclk_en), .idle_cont(idle_cont), .tx_en(tx_en), .rx_en(rx_en),
    .tx_msb_late(tx_msb_late), .rx_msb_late(rx_msb_late), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_take(tx_take), .tx_underrun(tx_underrun),
    .rx_wr(rx_wr), .rx_data(rx_data), .sclk_out(sclk_out), .sync_out(sync_out),
    .sdo(sdo), .sdi(sdi));

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  int per_rate = 100, aud_rate = 0;
  logic [15:0] fifo_q[$];

  // behavioural reference state
  int m_hc, m_bit, m_hd, m_fd, m_lvl, m_started;
  int m_sync, m_sdo, m_take, m_und, m_rxwr;
  logic [15:0] m_txw, m_rxw, m_rxd;

  // monitor state
  int toggles = 0, sync_rises = 0, frame_len = 0, rise_cnt = 0, idle_takes = 0, sdo_ones = 0;
  logic prev_sclk = 1'b0, prev_sync = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task start_bit();
    int p;
    m_sync = (m_bit == 0);
    if (tx_en && m_bit >= int'(tx_msb_late) && m_bit - int'(tx_msb_late) < 32) begin
      p = m_bit - int'(tx_msb_late);
      if (p % 16 == 0) begin
        if (tx_valid) begin m_txw = tx_data; m_take = 1; end
        else begin m_txw = 16'h0; m_und = 1; end
      end
      m_sdo = int'(m_txw[15 - p % 16]);
    end else m_sdo = 0;
  endtask

  task sample_rx();
    int p;
    if (rx_en && m_bit >= int'(rx_msb_late) && m_bit - int'(rx_msb_late) < 32) begin
      p = m_bit - int'(rx_msb_late);
      m_rxw[15 - p % 16] = sdi;
      if (p % 16 == 15) begin m_rxwr = 1; m_rxd = m_rxw; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hc = 0; m_bit = 0; m_hd = 0; m_fd = 0; m_lvl = 0; m_started = 0;
      m_sync = 0; m_sdo = 0; m_take = 0; m_und = 0; m_rxwr = 0;
      m_txw = '0; m_rxw = '0; m_rxd = '0;
    end else begin
      m_take = 0; m_und = 0; m_rxwr = 0;
      if (!(sclk_en && (idle_cont || tx_en || rx_en))) begin
        m_started = 0; m_lvl = 0; m_sync = 0; m_sdo = 0; m_hc = 0; m_bit = 0;
      end else if (m_started == 0) begin
        m_started = 1; m_hd = int'(sclk_div); m_fd = int'(sync_div);
        m_bit = 0; m_hc = 0; m_lvl = 0;
        start_bit();
      end else if (src_sel ? tick_periph : tick_audio) begin
        if (m_hc == m_hd) begin
          m_hc = 0;
          if (m_lvl == 1) begin
            m_lvl = 0;
            if (m_bit == m_fd) begin
              m_bit = 0; m_hd = int'(sclk_div); m_fd = int'(sync_div);
            end else m_bit++;
            start_bit();
          end else begin
            m_lvl = 1;
            sample_rx();
          end
        end else m_hc++;
      end
    end
  end

  // stimulus for ticks and serial input
  always @(negedge clk) begin
    tick_periph <= ($urandom % 100) < per_rate;
    tick_audio  <= ($urandom % 100) < aud_rate;
    sdi         <= 1'($urandom % 2);
  end

  // per-cycle comparison, monitor and FIFO model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R1", "sclk_out", int'(sclk_out), m_lvl);
      check("R3", "sync_out", int'(sync_out), m_sync);
      check("R5", "sdo", int'(sdo), m_sdo);
      check("R5", "tx_take", int'(tx_take), m_take);
      check("R7", "tx_underrun", int'(tx_underrun), m_und);
      check("R6", "rx_wr", int'(rx_wr), m_rxwr);
      check("R6", "rx_data", int'(rx_data), int'(m_rxd));
      if (sclk_out != prev_sclk) toggles++;
      if (sclk_out && !prev_sclk) rise_cnt++;
      if (sync_out && !prev_sync) begin frame_len = rise_cnt; rise_cnt = 0; sync_rises++; end
      if (!tx_en && tx_take) idle_takes++;
      if (!tx_en && sdo) sdo_ones++;
      prev_sclk = sclk_out;
      prev_sync = sync_out;
      if (m_take == 1 && fifo_q.size() > 0) void'(fifo_q.pop_front());
    end
    tx_valid <= (fifo_q.size() > 0);
    tx_data  <= (fifo_q.size() > 0) ? fifo_q[0] : 16'h0;
    if (cycles >= 100000) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected<%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    cyc(3);
    // R9: reset state
    check("R9", "reset sclk_out", int'(sclk_out), 0);
    check("R9", "reset sync_out", int'(sync_out), 0);
    check("R9", "reset sdo", int'(sdo), 0);
    check("R9", "reset strobes", int'(tx_take | tx_underrun | rx_wr), 0);
    check("R9", "reset rx_data", int'(rx_data), 0);
    rst_n = 1'b1;
    cyc(2);

    // phase A: MSB with sync, fast clock, FIFO drains into underrun (R5, R6, R7)
    fifo_q = '{16'hA5C3, 16'h8001, 16'h7FFE, 16'h1234, 16'hFFFF, 16'h0F0F};
    src_sel = 1'b1; per_rate = 100; aud_rate = 0;
    sclk_div = 9'd0; sync_div = 9'd39;
    tx_en = 1'b1; rx_en = 1'b1; sclk_en = 1'b1;
    cyc(420);

    // R4: divider change in mid-frame applies from the next frame
    fifo_q.push_back(16'hC001); fifo_q.push_back(16'h5AA5);
    base = sync_rises;
    wait (sync_rises == base + 1);
    cyc(12);
    sync_div = 9'd49; sclk_div = 9'd1;
    wait (sync_rises == base + 2);
    check("R4", "frame length before wrap", frame_len, 40);
    wait (sync_rises == base + 3);
    check("R4", "frame length after wrap", frame_len, 50);

    // R8: clock enable off holds the outputs low
    sclk_en = 1'b0;
    cyc(3);
    base = toggles;
    cyc(40);
    check("R8", "toggles with sclk_en clear", toggles - base, 0);

    // phase B: audio source, late transmit MSB (R2, R5)
    tx_msb_late = 1'b1; rx_msb_late = 1'b0;
    src_sel = 1'b0; aud_rate = 40; per_rate = 100;
    sclk_div = 9'd2; sync_div = 9'd35;
    fifo_q = '{16'h0001, 16'h8000, 16'hDEAD, 16'hBEEF, 16'h3C3C, 16'h9669};
    sclk_en = 1'b1;
    cyc(1500);
    // R2: unselected source ticks do not move the clock
    aud_rate = 0;
    cyc(5);
    base = toggles;
    cyc(60);
    check("R2", "toggles with only unselected source", toggles - base, 0);
    aud_rate = 40;
    cyc(300);

    // phase C: 32-bit frame with late receive MSB truncates the second word (R6)
    sclk_en = 1'b0;
    cyc(3);
    tx_msb_late = 1'b0; rx_msb_late = 1'b1;
    src_sel = 1'b1; per_rate = 70; sclk_div = 9'd0; sync_div = 9'd31;
    fifo_q = '{16'h1111, 16'h2222, 16'h4444, 16'h8888};
    sclk_en = 1'b1;
    cyc(600);

    // R8: gated mode stops with both directions off; continuous keeps running
    tx_en = 1'b0; rx_en = 1'b0; idle_cont = 1'b0;
    cyc(3);
    base = toggles;
    cyc(50);
    check("R8", "gated idle toggles", toggles - base, 0);
    idle_cont = 1'b1;
    fifo_q = '{16'h7777};
    cyc(3);
    base = toggles;
    cyc(120);
    check("R8", "continuous idle clock running", int'((toggles - base) > 0), 1);
    check("R5", "no takes with tx_en clear", idle_takes, 0);
    check("R5", "sdo low with tx_en clear", sdo_ones, 0);

    // phase D: default 128-bit frame, both MSBs late
    idle_cont = 1'b0; sclk_en = 1'b0;
    cyc(3);
    tx_msb_late = 1'b1; rx_msb_late = 1'b1;
    per_rate = 100; sclk_div = 9'd1; sync_div = 9'd127;
    fifo_q = '{16'hF00F, 16'h0FF0, 16'hAAAA, 16'h5555, 16'h8421, 16'h1248, 16'hFEDC, 16'h0123};
    tx_en = 1'b1; rx_en = 1'b1; sclk_en = 1'b1;
    cyc(1700);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule